// File: doc/BRIEF.md
# Dual-Read Replicated Word Store with Parity Repair

The block is a word-addressed data store built from two identical copies of the same array. Each copy serves one load port, so two loads complete in the same cycle whatever their addresses. A single store port writes both copies together. Each load returns its word one cycle after the request.

Every byte in each copy carries an even-parity bit. A load first checks the word in its own copy. If that word is damaged and the other copy holds a clean word at the same address, the port keeps its valid low for one cycle. During that cycle it writes the clean word back into its own copy. In the next cycle it delivers the clean word. If both copies are damaged at that address, the port returns its own copy's word with an uncorrectable flag.

A parameter can make stores exclusive with loads. A fault-injection input lets a store write inverted parity into one copy or both. A load request on a port during that port's repair cycle is not accepted, so callers leave that cycle idle.

Top module: `dlc_dual_load_cache`

## Requirements
- R1: A load request on either port in cycle t gives ld_valid_o high in cycle t+1 with the addressed word on that port's data output. ld_valid_o stays low when no request was accepted and no repair is in progress.
- R2: Both load ports accept requests in the same cycle, to different addresses or the same address, and both answer in cycle t+1 without stalling each other.
- R3: A store writes both copies in the same cycle. Byte enable bit i selects data bits 8i+7..8i, and bytes with a clear enable keep their previous value in both copies.
- R4: With STORE_BLOCKS_LOADS set (the default), a load request in the same cycle as a store is dropped: the port gives no valid in the next cycle.
- R5: Parity is kept per byte, as the XOR of the eight data bits. When st_inj_i bit k is set during a store, copy k stores inverted parity for the written bytes only.
- R6: If a load finds a parity error in its own copy (copy 0 for port 0, copy 1 for port 1) and the other copy is clean at that address, the port holds valid low in cycle t+1. In cycle t+2 it raises valid with the other copy's word, and ld_uerr_o stays low.
- R7: After a repair, the damaged copy holds the clean word with good parity, so a later load of that address on the same port answers in one cycle without an error.
- R8: If both copies have a parity error at the loaded address, the port raises valid in cycle t+1 with its own copy's word and ld_uerr_o high for that cycle. No repair takes place, so the next load of that address reports the error again.
- R9: While rst_ni is low and after it is released, ld_valid_o and ld_uerr_o are low. All words read as zero with good parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_req_i | input | 2 | Load request, one bit per port |
| ld_addr0_i | input | ADDR_W | Word address, load port 0 |
| ld_addr1_i | input | ADDR_W | Word address, load port 1 |
| ld_valid_o | output | 2 | Load result valid, one bit per port |
| ld_data0_o | output | DATA_W | Load data, port 0 |
| ld_data1_o | output | DATA_W | Load data, port 1 |
| ld_uerr_o | output | 2 | Uncorrectable error on the current result, per port |
| st_en_i | input | 1 | Store enable |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/BYTE_W | Store byte enables |
| st_inj_i | input | 2 | Store inverted parity into copy k (fault injection) |

## Verification
The bench corrupts one copy at a time and loads from the damaged side. A design that trusted its own copy would return the word on time with no gap. A design that skipped the write-back would show the same one-cycle bubble again on the next load. A byte-granular injection with a one-hot byte enable checks that parity follows only the written bytes; a word-wide parity scheme would flag or miss the wrong cases. Corrupting both copies checks that the result is flagged and delivered rather than silently repaired from bad data. Stores issued together with loads check that the dropped loads really produce nothing.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    RD_CLEAN = 2'd0,
    RD_FIX   = 2'd1,
    RD_FATAL = 2'd2
  } rd_stat_e;
endpackage

// File: rtl/dlc_par_gen.sv
module dlc_par_gen #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [NB-1:0]     par_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par_o[b] = ^data_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dlc_copy.sv
module dlc_copy #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [NB-1:0]     st_par_i,
  input  logic [NB-1:0]     st_be_i,
  input  logic              rep_we_i,
  input  logic [ADDR_W-1:0] rep_addr_i,
  input  logic [DATA_W-1:0] rep_data_i,
  input  logic [NB-1:0]     rep_par_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [NB-1:0]     ra_par_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic [NB-1:0]     rb_par_o
);
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [NB-1:0]     mem_p [DEPTH];

  // repair first, store bytes last so a same-address store wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_p[i] <= '0;
      end
    end else begin
      if (rep_we_i) begin
        mem_d[rep_addr_i] <= rep_data_i;
        mem_p[rep_addr_i] <= rep_par_i;
      end
      if (st_we_i) begin
        for (int b = 0; b < NB; b++) begin
          if (st_be_i[b]) begin
            mem_d[st_addr_i][b*BYTE_W +: BYTE_W] <= st_data_i[b*BYTE_W +: BYTE_W];
            mem_p[st_addr_i][b]                  <= st_par_i[b];
          end
        end
      end
    end
  end

  assign ra_data_o = mem_d[ra_addr_i];
  assign ra_par_o  = mem_p[ra_addr_i];
  assign rb_data_o = mem_d[rb_addr_i];
  assign rb_par_o  = mem_p[rb_addr_i];

  function automatic logic word_ok(input logic [DATA_W-1:0] d, input logic [NB-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < NB; b++) ok &= ((^d[b*BYTE_W +: BYTE_W]) == p[b]);
    return ok;
  endfunction

  // rewritten word must read back with clean parity
  assert_repair_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_we_i && !st_we_i) |=> word_ok(mem_d[$past(rep_addr_i)], mem_p[$past(rep_addr_i)]));
endmodule

// File: rtl/dlc_port.sv
module dlc_port
  import dlc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] own_data_i,
  input  logic [NB-1:0]     own_par_i,
  input  logic [DATA_W-1:0] peer_data_i,
  input  logic [NB-1:0]     peer_par_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              uerr_o,
  output logic              rep_we_o,
  output logic [ADDR_W-1:0] rep_addr_o,
  output logic [DATA_W-1:0] rep_data_o,
  output logic [NB-1:0]     rep_par_o
);
  logic              req_q, fix_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] fix_data_q;
  logic [NB-1:0]     own_calc, peer_calc;
  logic              own_ok, peer_ok, err_fix, accept;
  rd_stat_e          stat;

  dlc_par_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_own_chk  (.data_i(own_data_i),  .par_o(own_calc));
  dlc_par_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_peer_chk (.data_i(peer_data_i), .par_o(peer_calc));

  assign own_ok  = (own_calc == own_par_i);
  assign peer_ok = (peer_calc == peer_par_i);

  always_comb begin
    if (own_ok)       stat = RD_CLEAN;
    else if (peer_ok) stat = RD_FIX;
    else              stat = RD_FATAL;
  end

  assign err_fix = req_q && (stat == RD_FIX);
  // no new request accepted in the repair cycle
  assign accept  = req_i && !err_fix;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      addr_q     <= '0;
      fix_q      <= 1'b0;
      fix_data_q <= '0;
    end else begin
      req_q <= accept;
      fix_q <= err_fix;
      if (accept)  addr_q     <= addr_i;
      if (err_fix) fix_data_q <= peer_data_i;
    end
  end

  assign rd_addr_o  = addr_q;
  assign valid_o    = (req_q && (stat != RD_FIX)) || fix_q;
  assign data_o     = fix_q ? fix_data_q : own_data_i;
  assign uerr_o     = req_q && (stat == RD_FATAL);
  assign rep_we_o   = err_fix;
  assign rep_addr_o = addr_q;
  assign rep_data_o = peer_data_i;
  assign rep_par_o  = peer_par_i;

  assert_valid_has_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(req_i) || $past(rep_we_o)));
  assert_fix_delivers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_we_o |=> (valid_o && !uerr_o));
  assert_uerr_no_repair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uerr_o |-> (!rep_we_o && valid_o));
endmodule

// File: rtl/dlc_dual_load_cache.sv
module dlc_dual_load_cache #(
  parameter int ADDR_W             = 6,
  parameter int DATA_W             = 32,
  parameter int BYTE_W             = 8,
  parameter bit STORE_BLOCKS_LOADS = 1'b1,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ld_req_i,
  input  logic [ADDR_W-1:0] ld_addr0_i,
  input  logic [ADDR_W-1:0] ld_addr1_i,
  output logic [1:0]        ld_valid_o,
  output logic [DATA_W-1:0] ld_data0_o,
  output logic [DATA_W-1:0] ld_data1_o,
  output logic [1:0]        ld_uerr_o,
  input  logic              st_en_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [NB-1:0]     st_be_i,
  input  logic [1:0]        st_inj_i
);
  logic [ADDR_W-1:0] ld_addr  [2];
  logic [DATA_W-1:0] ld_data  [2];
  logic [ADDR_W-1:0] rd_addr  [2];
  logic [DATA_W-1:0] own_d    [2];
  logic [NB-1:0]     own_p    [2];
  logic [DATA_W-1:0] xr_d     [2];
  logic [NB-1:0]     xr_p     [2];
  logic [1:0]        rep_we;
  logic [ADDR_W-1:0] rep_addr [2];
  logic [DATA_W-1:0] rep_data [2];
  logic [NB-1:0]     rep_par  [2];
  logic [NB-1:0]     st_par;
  logic [1:0]        req_gated;

  assign ld_addr[0] = ld_addr0_i;
  assign ld_addr[1] = ld_addr1_i;
  assign ld_data0_o = ld_data[0];
  assign ld_data1_o = ld_data[1];

  dlc_par_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_st_par (.data_i(st_data_i), .par_o(st_par));

  if (STORE_BLOCKS_LOADS) begin : g_excl
    assign req_gated = st_en_i ? 2'b00 : ld_req_i;
  end else begin : g_shared
    assign req_gated = ld_req_i;
  end

  for (genvar k = 0; k < 2; k++) begin : g_lane
    dlc_copy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_copy (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .st_we_i   (st_en_i),
      .st_addr_i (st_addr_i),
      .st_data_i (st_data_i),
      .st_par_i  (st_par ^ {NB{st_inj_i[k]}}),
      .st_be_i   (st_be_i),
      .rep_we_i  (rep_we[k]),
      .rep_addr_i(rep_addr[k]),
      .rep_data_i(rep_data[k]),
      .rep_par_i (rep_par[k]),
      .ra_addr_i (rd_addr[k]),
      .rb_addr_i (rd_addr[1-k]),
      .ra_data_o (own_d[k]),
      .ra_par_o  (own_p[k]),
      .rb_data_o (xr_d[1-k]),
      .rb_par_o  (xr_p[1-k])
    );

    dlc_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_gated[k]),
      .addr_i     (ld_addr[k]),
      .own_data_i (own_d[k]),
      .own_par_i  (own_p[k]),
      .peer_data_i(xr_d[k]),
      .peer_par_i (xr_p[k]),
      .rd_addr_o  (rd_addr[k]),
      .valid_o    (ld_valid_o[k]),
      .data_o     (ld_data[k]),
      .uerr_o     (ld_uerr_o[k]),
      .rep_we_o   (rep_we[k]),
      .rep_addr_o (rep_addr[k]),
      .rep_data_o (rep_data[k]),
      .rep_par_o  (rep_par[k])
    );

    if (STORE_BLOCKS_LOADS) begin : g_excl_chk
      assert_store_blocks_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_en_i && ld_req_i[k] && !rep_we[k]) |=> !ld_valid_o[k]);
    end
  end
endmodule

// File: tb/dlc_dual_load_cache_tb_top.sv
module dlc_dual_load_cache_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    int              cyc;
    logic            v;
    logic [DW-1:0]   d;
    logic            ue;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ld_req;
  logic [AW-1:0] ld_a0, ld_a1;
  logic [1:0] ld_valid, ld_uerr;
  logic [DW-1:0] ld_d0, ld_d1;
  logic st_en;
  logic [AW-1:0] st_a;
  logic [DW-1:0] st_d;
  logic [NB-1:0] st_be;
  logic [1:0] st_inj;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit run = 1'b0;
  exp_t qs [2][$];
  logic [DW-1:0] mdl [DEPTH];
  logic [NB-1:0] bad [2][DEPTH];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dlc_dual_load_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_req_i(ld_req), .ld_addr0_i(ld_a0), .ld_addr1_i(ld_a1),
    .ld_valid_o(ld_valid), .ld_data0_o(ld_d0), .ld_data1_o(ld_d1), .ld_uerr_o(ld_uerr),
    .st_en_i(st_en), .st_addr_i(st_a), .st_data_i(st_d), .st_be_i(st_be), .st_inj_i(st_inj)
  );

  task automatic push(input int p, input int c, input logic v, input logic [DW-1:0] d,
                      input logic ue, input string tag);
    exp_t e;
    e.cyc = c; e.v = v; e.d = d; e.ue = ue; e.tag = tag;
    qs[p].push_back(e);
  endtask

  task automatic step(input logic [1:0] ld, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                      input logic st, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [NB-1:0] be, input logic [1:0] inj, input string tag);
    @(negedge clk);
    ld_req = ld; ld_a0 = a0; ld_a1 = a1;
    st_en = st; st_a = sa; st_d = sd; st_be = be; st_inj = inj;
    for (int p = 0; p < 2; p++) begin
      if (ld[p]) begin
        logic [AW-1:0] a;
        a = (p == 0) ? a0 : a1;
        if (st) push(p, cyc + 1, 1'b0, '0, 1'b0, {tag, " R4"});
        else if (bad[p][a] == '0) push(p, cyc + 1, 1'b1, mdl[a], 1'b0, tag);
        else if (bad[1-p][a] == '0) begin
          push(p, cyc + 1, 1'b0, '0, 1'b0, {tag, " R6 bubble"});
          push(p, cyc + 2, 1'b1, mdl[a], 1'b0, {tag, " R6 fixed"});
          bad[p][a] = '0;
        end else push(p, cyc + 1, 1'b1, mdl[a], 1'b1, {tag, " R8"});
      end
    end
    if (st) begin
      for (int b = 0; b < NB; b++) if (be[b]) mdl[sa][b*8 +: 8] = sd[b*8 +: 8];
      for (int k = 0; k < 2; k++) bad[k][sa] = (bad[k][sa] & ~be) | (inj[k] ? be : '0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, '0, '0, 1'b0, '0, '0, '0, 2'b00, "idle");
  endtask

  task automatic check_port(input int p);
    logic v, ue;
    logic [DW-1:0] d;
    bit hit;
    v = ld_valid[p]; ue = ld_uerr[p]; d = (p == 0) ? ld_d0 : ld_d1;
    while (qs[p].size() > 0 && qs[p][0].cyc < cyc) begin
      n_chk++; n_fail++;
      $display("FAIL %s port%0d: result never sampled, actual cycle %0d expected cycle %0d",
               qs[p][0].tag, p, cyc, qs[p][0].cyc);
      void'(qs[p].pop_front());
    end
    hit = (qs[p].size() > 0 && qs[p][0].cyc == cyc);
    if (hit) begin
      exp_t e;
      e = qs[p].pop_front();
      n_chk++;
      if (v !== e.v || (e.v && (d !== e.d || ue !== e.ue)) || (!e.v && ue !== 1'b0)) begin
        n_fail++;
        $display("FAIL %s port%0d cyc %0d: actual v=%b d=%h ue=%b expected v=%b d=%h ue=%b",
                 e.tag, p, cyc, v, d, ue, e.v, e.d, e.ue);
      end
    end else if (v !== 1'b0 || ue !== 1'b0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 port%0d cyc %0d: unexpected actual v=%b ue=%b expected v=0 ue=0",
               p, cyc, v, ue);
    end
  endtask

  always @(negedge clk) if (run) for (int p = 0; p < 2; p++) check_port(p);

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = '0; bad[0][i] = '0; bad[1][i] = '0;
    end
    rst_n = 1'b0; ld_req = '0; ld_a0 = '0; ld_a1 = '0;
    st_en = 1'b0; st_a = '0; st_d = '0; st_be = '0; st_inj = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (ld_valid !== 2'b00 || ld_uerr !== 2'b00) begin
      n_fail++;
      $display("FAIL R9 in reset: actual v=%b ue=%b expected 00 00", ld_valid, ld_uerr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (ld_valid !== 2'b00 || ld_uerr !== 2'b00) begin
      n_fail++;
      $display("FAIL R9 after reset: actual v=%b ue=%b expected 00 00", ld_valid, ld_uerr);
    end
    run = 1'b1;
    // R9: words read as zero after reset
    step(2'b11, 6'd0, 6'd63, 1'b0, '0, '0, '0, 2'b00, "R9 zero");
    // R3: full stores
    step(2'b00, '0, '0, 1'b1, 6'd1, 32'hDEAD_BEEF, 4'hF, 2'b00, "R3 st");
    step(2'b00, '0, '0, 1'b1, 6'd2, 32'h1234_5678, 4'hF, 2'b00, "R3 st");
    step(2'b00, '0, '0, 1'b1, 6'd63, 32'hA5A5_0F0F, 4'hF, 2'b00, "R3 st");
    // R1/R2: parallel loads, different and same address
    step(2'b11, 6'd1, 6'd2, 1'b0, '0, '0, '0, 2'b00, "R1 R2 diff");
    step(2'b11, 6'd63, 6'd63, 1'b0, '0, '0, '0, 2'b00, "R2 same");
    step(2'b01, 6'd2, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R1 p0 only");
    step(2'b10, 6'd0, 6'd1, 1'b0, '0, '0, '0, 2'b00, "R1 p1 only");
    // R3: partial stores
    step(2'b00, '0, '0, 1'b1, 6'd1, 32'h0000_00AA, 4'b0001, 2'b00, "R3 part");
    step(2'b00, '0, '0, 1'b1, 6'd2, 32'hCC00_0000, 4'b1000, 2'b00, "R3 part");
    step(2'b11, 6'd1, 6'd2, 1'b0, '0, '0, '0, 2'b00, "R3 readback");
    step(2'b11, 6'd2, 6'd1, 1'b0, '0, '0, '0, 2'b00, "R3 cross");
    // R4: store with loads blocks them
    step(2'b11, 6'd1, 6'd2, 1'b1, 6'd5, 32'h5555_AAAA, 4'hF, 2'b00, "blocked");
    step(2'b11, 6'd5, 6'd5, 1'b0, '0, '0, '0, 2'b00, "R4 after");
    // R6/R7: copy 0 damaged, port 0 repairs
    step(2'b00, '0, '0, 1'b1, 6'd7, 32'h0BAD_F00D, 4'hF, 2'b01, "R5 inj0");
    step(2'b10, 6'd0, 6'd7, 1'b0, '0, '0, '0, 2'b00, "R6 p1 clean");
    step(2'b01, 6'd7, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R6 p0");
    idle(1);
    step(2'b01, 6'd7, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R7 p0 again");
    // copy 1 damaged, port 1 repairs
    step(2'b00, '0, '0, 1'b1, 6'd9, 32'hFACE_0001, 4'hF, 2'b10, "R5 inj1");
    step(2'b11, 6'd9, 6'd9, 1'b0, '0, '0, '0, 2'b00, "R6 p1");
    idle(1);
    step(2'b10, 6'd0, 6'd9, 1'b0, '0, '0, '0, 2'b00, "R7 p1 again");
    // R5: per-byte parity, injected on one byte only
    step(2'b00, '0, '0, 1'b1, 6'd11, 32'h7788_99AB, 4'hF, 2'b00, "R5 base");
    step(2'b00, '0, '0, 1'b1, 6'd11, 32'h0000_00EE, 4'b0001, 2'b01, "R5 byte inj");
    step(2'b01, 6'd11, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R5 byte load");
    idle(1);
    // clean-parity store over damaged bytes clears them
    step(2'b00, '0, '0, 1'b1, 6'd12, 32'h1111_2222, 4'b0010, 2'b01, "R5 inj b1");
    step(2'b00, '0, '0, 1'b1, 6'd12, 32'h3333_4444, 4'b0010, 2'b00, "R5 overwrite");
    step(2'b01, 6'd12, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R5 healed");
    // R8: both copies damaged
    step(2'b00, '0, '0, 1'b1, 6'd20, 32'hBEEF_CAFE, 4'hF, 2'b11, "R8 inj both");
    step(2'b11, 6'd20, 6'd20, 1'b0, '0, '0, '0, 2'b00, "R8 both");
    step(2'b01, 6'd20, 6'd0, 1'b0, '0, '0, '0, 2'b00, "R8 repeat");
    // mixed traffic, no injection
    for (int i = 0; i < 400; i++) begin
      logic st;
      st = ($urandom_range(0, 3) == 0);
      step(2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)),
           st, 6'($urandom_range(0, 63)), $urandom, 4'($urandom_range(0, 15)), 2'b00,
           "R1 R3 mix");
    end
    idle(4);
    for (int p = 0; p < 2; p++) begin
      if (qs[p].size() != 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1 port%0d: actual %0d pending expected 0", p, qs[p].size());
      end
    end
    finish_run();
  end
endmodule